// File: doc/BRIEF.md
# Warp Divergence Reconvergence Stack

This block keeps, for one warp of parallel lanes, a bounded stack of execution contexts. Each context holds a program counter, the set of lanes that run at that counter, the counter at which those lanes rejoin their siblings, a call-depth field and a cycle stamp. The issue logic reads the top context to learn which lanes to enable and where to fetch next. After each issued instruction it asks the block to refresh the stack.

A refresh request supplies every lane's next counter, a per-lane finished flag and the rejoin counter of the current branch. The block splits the live lanes of the top context into groups that share a next counter, one group per clock. When the lanes disagree, the top context becomes the rejoin context. The groups are then stacked above it, and a group that already sits at the rejoin point is not stacked. If every live lane has finished, the stack pops one level. A launch discards all state and starts the warp with one context.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the top level is 0, the top counter and top rejoin counter are all ones, and the top mask, call depth, stamp, busy, done and err are 0.
- R2: A launch clears every context and writes the given counter and lane mask into level 0, which becomes the top; its rejoin counter is all ones. A launch beats an update request in the same cycle and aborts a running update, and no done pulse follows.
- R3: Lanes are scanned from the highest index to 0, and bit i of every mask is lane i. Finished lanes leave the live set. The highest live lane fixes the group counter, and every live lane with an equal next counter joins the group. One group is handled per clock.
- R4: If the live lanes form a single group, the top context takes the group counter and mask, keeps its rejoin counter, and the level is unchanged.
- R5: If the lanes split and the branch rejoin counter differs from the top rejoin counter, the top context's counter becomes the branch rejoin counter and its stamp records the free-running cycle count. Its mask is kept. The groups are then stacked above it in scan order, each with the branch rejoin counter, call depth 0 and stamp 0. The last written context becomes the top.
- R6: If the lanes split and the branch rejoin counter equals the top rejoin counter, no rejoin context is made and the groups are written from the current top level upward.
- R7: Once the lanes have split, a group whose counter equals the branch rejoin counter is not written.
- R8: If no live lane remains at the start of an update, the level drops by one. At level 0 this sets err and leaves the level at 0.
- R9: An update whose top mask is all zero sets err, changes no context and still ends with a done pulse.
- R10: A write beyond level DEPTH-1 sets err, drops the writes of that clock, ends the update, and leaves the top level as it was before the update.
- R11: busy is high while groups are being handled. Every accepted update ends with done high for exactly one cycle. Update requests while busy are ignored.
- R12: err stays set until reset; a launch does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_vld | input | 1 | Start the warp afresh |
| launch_pc | input | PC_W | Start counter |
| launch_mask | input | LANES | Initial lane mask |
| upd_vld | input | 1 | Refresh request |
| upd_next_pc | input | LANES*PC_W | Next counter per lane, lane i at bits i*PC_W upward |
| upd_done | input | LANES | Per-lane finished flag |
| upd_rpc | input | PC_W | Rejoin counter of the current branch |
| top_pc | output | PC_W | Top context counter |
| top_mask | output | LANES | Top context lane mask |
| top_rpc | output | PC_W | Top context rejoin counter |
| top_cdepth | output | CD_W | Top context call depth |
| top_stamp | output | ST_W | Top context divergence stamp |
| top_level | output | clog2(DEPTH) | Index of the top context |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse at the end of an update |
| err | output | 1 | Sticky error flag |

## Verification
A launch and a refresh request can meet in the same cycle, either because both arrive together or because a launch comes while a multi-clock refresh is still running. The bench drives both strobes in one cycle, and in a second case it raises a launch one clock after a split refresh was accepted. In both cases the top context must show exactly the launch values at level 0, busy must be low, and no done pulse may appear in the following cycles. A second overlap is a new request while busy: the bench holds a different request high during a running refresh and expects the result of the first request alone, with a single done pulse.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/simt_group_pick.sv
module simt_group_pick #(
  parameter int LANES = 4,
  parameter int PC_W  = 8
) (
  input  logic [LANES-1:0]      rem,
  input  logic [LANES-1:0]      fin,
  input  logic [LANES*PC_W-1:0] pcs,
  output logic [LANES-1:0]      live,
  output logic                  have,
  output logic [LANES-1:0]      grp,
  output logic [PC_W-1:0]       gpc,
  output logic [LANES-1:0]      left
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  function automatic logic [PC_W-1:0] lane_pc(input logic [LANES*PC_W-1:0] v,
                                              input int unsigned i);
    return v[i*PC_W +: PC_W];
  endfunction

  logic [LW-1:0] lead;
  logic          found;

  assign live = rem & ~fin;
  assign have = |live;

  // highest live lane leads the group
  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (live[i] && !found) begin
        lead  = LW'(i);
        found = 1'b1;
      end
    end
  end

  assign gpc = lane_pc(pcs, int'(lead));

  always_comb begin
    for (int i = 0; i < LANES; i++)
      grp[i] = live[i] && (lane_pc(pcs, i) == gpc);
  end

  assign left = live & ~grp;

endmodule

// File: rtl/simt_entry_file.sv
module simt_entry_file #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  parameter int PC_W  = 8,
  parameter int CD_W  = 4,
  parameter int ST_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [PC_W-1:0]          clr_pc,
  input  logic [LANES-1:0]         clr_mask,
  input  logic                     wa_en,
  input  logic [$clog2(DEPTH)-1:0] wa_idx,
  input  logic [PC_W-1:0]          wa_pc,
  input  logic [ST_W-1:0]          wa_stamp,
  input  logic                     wb_en,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  input  logic [PC_W-1:0]          wb_pc,
  input  logic [LANES-1:0]         wb_mask,
  input  logic [PC_W-1:0]          wb_rpc,
  input  logic                     wb_div,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [PC_W-1:0]          rd_pc,
  output logic [LANES-1:0]         rd_mask,
  output logic [PC_W-1:0]          rd_rpc,
  output logic [CD_W-1:0]          rd_cd,
  output logic [ST_W-1:0]          rd_stamp
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH*PC_W-1:0]  pc_flat;
  logic [DEPTH*LANES-1:0] mask_flat;
  logic [DEPTH*PC_W-1:0]  rpc_flat;
  logic [DEPTH*CD_W-1:0]  cd_flat;
  logic [DEPTH*ST_W-1:0]  st_flat;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [IW-1:0] MY = IW'(e);
    logic [PC_W-1:0]  pc_r;
    logic [LANES-1:0] mask_r;
    logic [PC_W-1:0]  rpc_r;
    logic [CD_W-1:0]  cd_r;
    logic [ST_W-1:0]  st_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_r   <= '1;
        mask_r <= '0;
        rpc_r  <= '1;
        cd_r   <= '0;
        st_r   <= '0;
      end else if (clr) begin
        pc_r   <= (e == 0) ? clr_pc : '1;
        mask_r <= (e == 0) ? clr_mask : '0;
        rpc_r  <= '1;
        cd_r   <= '0;
        st_r   <= '0;
      end else begin
        if (wa_en && wa_idx == MY) begin
          pc_r <= wa_pc;
          st_r <= wa_stamp;
        end
        if (wb_en && wb_idx == MY) begin
          pc_r   <= wb_pc;
          mask_r <= wb_mask;
          rpc_r  <= wb_rpc;
          st_r   <= '0;
          if (wb_div) cd_r <= '0;
        end
      end
    end

    assign pc_flat[e*PC_W +: PC_W]    = pc_r;
    assign mask_flat[e*LANES +: LANES] = mask_r;
    assign rpc_flat[e*PC_W +: PC_W]   = rpc_r;
    assign cd_flat[e*CD_W +: CD_W]    = cd_r;
    assign st_flat[e*ST_W +: ST_W]    = st_r;
  end

  assign rd_pc    = pc_flat[rd_idx*PC_W +: PC_W];
  assign rd_mask  = mask_flat[rd_idx*LANES +: LANES];
  assign rd_rpc   = rpc_flat[rd_idx*PC_W +: PC_W];
  assign rd_cd    = cd_flat[rd_idx*CD_W +: CD_W];
  assign rd_stamp = st_flat[rd_idx*ST_W +: ST_W];

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 8,
  parameter int DEPTH = 2 * LANES,
  parameter int CD_W  = 4,
  parameter int ST_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch_vld,
  input  logic [PC_W-1:0]          launch_pc,
  input  logic [LANES-1:0]         launch_mask,
  input  logic                     upd_vld,
  input  logic [LANES*PC_W-1:0]    upd_next_pc,
  input  logic [LANES-1:0]         upd_done,
  input  logic [PC_W-1:0]          upd_rpc,
  output logic [PC_W-1:0]          top_pc,
  output logic [LANES-1:0]         top_mask,
  output logic [PC_W-1:0]          top_rpc,
  output logic [CD_W-1:0]          top_cdepth,
  output logic [ST_W-1:0]          top_stamp,
  output logic [$clog2(DEPTH)-1:0] top_level,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);
  localparam int IW = $clog2(DEPTH);
  localparam int WW = IW + 1;
  localparam logic [WW-1:0] DEPTH_W = WW'(DEPTH);

  function automatic logic [WW-1:0] bump(input logic [WW-1:0] p, input logic en);
    return p + {{(WW-1){1'b0}}, en};
  endfunction

  run_state_e             state_q;
  logic [LANES-1:0]       rem_q;
  logic [LANES*PC_W-1:0]  lpc_q;
  logic [LANES-1:0]       ldn_q;
  logic [PC_W-1:0]        brpc_q;
  logic [PC_W-1:0]        oldr_q;
  logic                   div_q;
  logic [WW-1:0]          wptr_q;
  logic [IW-1:0]          top_q;
  logic                   done_q;
  logic                   err_q;
  logic [ST_W-1:0]        cyc_q;

  // named internal events
  logic             running, accept, empty_top;
  logic [LANES-1:0] g_live, g_grp, g_left;
  logic             g_have;
  logic [PC_W-1:0]  g_gpc;
  logic             start_div, div_now, rc_wr, skip, gp_wr, ovf, fin, under;
  logic [WW-1:0]    wb_pos, wend;

  assign running   = (state_q == ST_RUN);
  assign accept    = (state_q == ST_IDLE) && upd_vld && !launch_vld;
  assign empty_top = ~|top_mask;

  simt_group_pick #(.LANES(LANES), .PC_W(PC_W)) u_pick (
    .rem(rem_q), .fin(ldn_q), .pcs(lpc_q),
    .live(g_live), .have(g_have), .grp(g_grp), .gpc(g_gpc), .left(g_left)
  );

  assign start_div = !div_q && g_have && (g_left != '0);
  assign div_now   = div_q || start_div;
  assign rc_wr     = start_div && (brpc_q != oldr_q);
  assign wb_pos    = bump(wptr_q, rc_wr);
  assign skip      = div_now && (g_gpc == brpc_q);
  assign gp_wr     = g_have && !skip;
  assign wend      = bump(wb_pos, gp_wr);
  assign ovf       = (rc_wr && wptr_q >= DEPTH_W) || (gp_wr && wb_pos >= DEPTH_W);
  assign fin       = !g_have || (g_left == '0) || ovf;
  assign under     = (wend == '0);

  simt_entry_file #(.DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W), .CD_W(CD_W), .ST_W(ST_W)) u_file (
    .clk(clk), .rst_n(rst_n),
    .clr(launch_vld), .clr_pc(launch_pc), .clr_mask(launch_mask),
    .wa_en(running && rc_wr && !ovf), .wa_idx(wptr_q[IW-1:0]), .wa_pc(brpc_q), .wa_stamp(cyc_q),
    .wb_en(running && gp_wr && !ovf), .wb_idx(wb_pos[IW-1:0]), .wb_pc(g_gpc), .wb_mask(g_grp),
    .wb_rpc(div_now ? brpc_q : oldr_q), .wb_div(div_now),
    .rd_idx(top_q),
    .rd_pc(top_pc), .rd_mask(top_mask), .rd_rpc(top_rpc), .rd_cd(top_cdepth), .rd_stamp(top_stamp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      lpc_q   <= '0;
      ldn_q   <= '0;
      brpc_q  <= '0;
      oldr_q  <= '0;
      div_q   <= 1'b0;
      wptr_q  <= '0;
      top_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cyc_q   <= '0;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
      done_q <= 1'b0;
      if (launch_vld) begin
        state_q <= ST_IDLE;
        top_q   <= '0;
        div_q   <= 1'b0;
      end else if (accept) begin
        if (empty_top) begin
          err_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          rem_q   <= top_mask;
          lpc_q   <= upd_next_pc;
          ldn_q   <= upd_done;
          brpc_q  <= upd_rpc;
          oldr_q  <= top_rpc;
          div_q   <= 1'b0;
          wptr_q  <= {1'b0, top_q};
        end
      end else if (running) begin
        rem_q  <= g_left;
        div_q  <= div_now;
        wptr_q <= wend;
        if (fin) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (ovf || under) err_q <= 1'b1;
          else              top_q <= IW'(wend - WW'(1));
        end
      end
    end
  end

  assign top_level = top_q;
  assign busy      = running;
  assign done      = done_q;
  assign err       = err_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err_q |=> err_q);

  // R2
  launch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_vld |=> (!busy && !done_q));

  // R3
  group_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && g_have) |-> (((g_grp & ~g_live) == '0) && (g_grp != '0)));

  // R5
  top_mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !err_q) |-> (top_mask != '0));

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(launch_vld)) |-> done_q);

endmodule

// File: tb/sim_simt_reconv_stack.sv
module sim_simt_reconv_stack;
  localparam int LANES = 4;
  localparam int PC_W  = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_vld = 1'b0;
  logic [7:0] launch_pc = '0;
  logic [3:0] launch_mask = '0;
  logic upd_vld = 1'b0;
  logic [31:0] upd_next_pc = '0;
  logic [3:0] upd_done = '0;
  logic [7:0] upd_rpc = '0;
  logic [7:0] top_pc, top_rpc;
  logic [3:0] top_mask, top_cdepth;
  logic [15:0] top_stamp;
  logic [1:0] top_level;
  logic busy, done, err;

  int checks = 0;
  int failures = 0;
  logic [15:0] cnt;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 16'd1;
  end

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .CD_W(4), .ST_W(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .launch_vld(launch_vld), .launch_pc(launch_pc), .launch_mask(launch_mask),
    .upd_vld(upd_vld), .upd_next_pc(upd_next_pc), .upd_done(upd_done), .upd_rpc(upd_rpc),
    .top_pc(top_pc), .top_mask(top_mask), .top_rpc(top_rpc), .top_cdepth(top_cdepth),
    .top_stamp(top_stamp), .top_level(top_level),
    .busy(busy), .done(done), .err(err)
  );

  typedef struct packed {
    logic        upd;
    logic [7:0]  a;
    logic [3:0]  m;
    logic [31:0] npc;
    logic [3:0]  dn;
    logic [7:0]  e_pc;
    logic [3:0]  e_mask;
    logic [7:0]  e_rpc;
    logic [1:0]  e_lvl;
    logic        e_err;
  } vec_t;

  // npc is {lane3, lane2, lane1, lane0}; a is launch counter or branch rejoin counter
  localparam vec_t VECS [9] = '{
    '{1'b0, 8'h10, 4'hF, 32'h0,        4'h0, 8'h10, 4'hF, 8'hFF, 2'd0, 1'b0}, // R2 launch
    '{1'b1, 8'h40, 4'h0, 32'h14141414, 4'h0, 8'h14, 4'hF, 8'hFF, 2'd0, 1'b0}, // R4 single group
    '{1'b1, 8'h40, 4'h0, 32'h20203030, 4'h0, 8'h30, 4'h3, 8'h40, 2'd2, 1'b0}, // R5 R3 split
    '{1'b1, 8'h40, 4'h0, 32'h00004034, 4'h0, 8'h34, 4'h1, 8'h40, 2'd2, 1'b0}, // R6 R7 skip
    '{1'b1, 8'h40, 4'h0, 32'h0,        4'h1, 8'h20, 4'hC, 8'h40, 2'd1, 1'b0}, // R8 pop
    '{1'b1, 8'h40, 4'h0, 32'h40400000, 4'h0, 8'h40, 4'hC, 8'h40, 2'd1, 1'b0}, // R4 keep rpc
    '{1'b1, 8'h40, 4'h0, 32'h0,        4'hC, 8'h40, 4'hF, 8'hFF, 2'd0, 1'b0}, // R8 pop
    '{1'b1, 8'h99, 4'h0, 32'h00444444, 4'h8, 8'h44, 4'h7, 8'hFF, 2'd0, 1'b0}, // R3 done lane dropped
    '{1'b1, 8'h99, 4'h0, 32'h0,        4'hF, 8'h44, 4'h7, 8'hFF, 2'd0, 1'b1}  // R8 underflow
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    launch_vld = 1'b0;
    upd_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_launch(input logic [7:0] pc, input logic [3:0] m);
    @(negedge clk);
    launch_vld = 1'b1; launch_pc = pc; launch_mask = m;
    @(negedge clk);
    launch_vld = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, {31'b0, done}, 32'd1);
    @(negedge clk);
    chk({tag, " done one cycle"}, {31'b0, done}, 32'd0);
  endtask

  task automatic do_update(input logic [31:0] npc, input logic [3:0] dn, input logic [7:0] rpc,
                           input string tag);
    @(negedge clk);
    upd_vld = 1'b1; upd_next_pc = npc; upd_done = dn; upd_rpc = rpc;
    @(negedge clk);
    upd_vld = 1'b0;
    wait_done(tag);
  endtask

  task automatic chk_top(input string tag, input logic [7:0] pc, input logic [3:0] m,
                         input logic [7:0] rpc, input logic [1:0] lvl, input logic e);
    chk({tag, " pc"}, {24'b0, top_pc}, {24'b0, pc});
    chk({tag, " mask"}, {28'b0, top_mask}, {28'b0, m});
    chk({tag, " rpc"}, {24'b0, top_rpc}, {24'b0, rpc});
    chk({tag, " level"}, {30'b0, top_level}, {30'b0, lvl});
    chk({tag, " err"}, {31'b0, err}, {31'b0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    logic [15:0] c0;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk_top("R1 reset", 8'hFF, 4'h0, 8'hFF, 2'd0, 1'b0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 stamp", {16'b0, top_stamp}, 32'd0);
    chk("R1 cdepth", {28'b0, top_cdepth}, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 9; k++) begin
      v = VECS[k];
      if (v.upd) do_update(v.npc, v.dn, v.a, $sformatf("R3-group table v%0d", k));
      else       do_launch(v.a, v.m);
      chk_top($sformatf("table v%0d (R2 R4 R5 R6 R7 R8)", k), v.e_pc, v.e_mask, v.e_rpc, v.e_lvl, v.e_err);
    end

    // R9 empty top mask
    do_reset();
    do_launch(8'h00, 4'h0);
    do_update(32'h11111111, 4'h0, 8'h22, "R9");
    chk_top("R9 empty mask", 8'h00, 4'h0, 8'hFF, 2'd0, 1'b1);
    chk("R9 busy", {31'b0, busy}, 32'd0);

    // R10 overflow at DEPTH 4
    do_reset();
    do_launch(8'h10, 4'hF);
    do_update(32'hA1B1B1B1, 4'h0, 8'hC1, "R10 step1");
    chk_top("R10 step1", 8'hB1, 4'h7, 8'hC1, 2'd2, 1'b0);
    do_update(32'h00A2B2B2, 4'h0, 8'hC2, "R10 step2");
    chk_top("R10 overflow", 8'hC2, 4'h7, 8'hC1, 2'd2, 1'b1);

    // R12 launch keeps err
    do_launch(8'h10, 4'hF);
    chk_top("R12 sticky after launch", 8'h10, 4'hF, 8'hFF, 2'd0, 1'b1);

    // R11 request while busy ignored; R5 stamp
    do_reset();
    do_launch(8'h10, 4'hF);
    @(negedge clk);
    c0 = cnt;
    upd_vld = 1'b1; upd_next_pc = 32'h20204040; upd_done = 4'h0; upd_rpc = 8'h40;
    @(negedge clk);
    chk("R11 busy after accept", {31'b0, busy}, 32'd1);
    upd_next_pc = 32'h55555555; upd_rpc = 8'h66;
    @(negedge clk);
    upd_vld = 1'b0;
    wait_done("R11 ignore");
    chk_top("R11 ignored request", 8'h20, 4'hC, 8'h40, 2'd1, 1'b0);
    chk("R5 group stamp zero", {16'b0, top_stamp}, 32'd0);
    chk("R5 group cdepth zero", {28'b0, top_cdepth}, 32'd0);
    chk("R11 idle after", {31'b0, busy}, 32'd0);
    do_update(32'h0, 4'hF, 8'h40, "R5 pop");
    chk_top("R5 rejoin context", 8'h40, 4'hF, 8'hFF, 2'd0, 1'b0);
    chk("R5 rejoin stamp", {16'b0, top_stamp}, {16'b0, c0 + 16'd1});

    // R2 launch and update in the same cycle
    @(negedge clk);
    launch_vld = 1'b1; launch_pc = 8'h60; launch_mask = 4'h5;
    upd_vld = 1'b1; upd_next_pc = 32'h00200030; upd_done = 4'h0; upd_rpc = 8'h40;
    @(negedge clk);
    launch_vld = 1'b0; upd_vld = 1'b0;
    chk_top("R2 launch wins", 8'h60, 4'h5, 8'hFF, 2'd0, 1'b0);
    chk("R2 no busy", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R2 no done", {31'b0, done}, 32'd0);

    // R2 launch aborts running update
    upd_vld = 1'b1;
    @(negedge clk);
    upd_vld = 1'b0;
    chk("R2 busy before abort", {31'b0, busy}, 32'd1);
    launch_vld = 1'b1; launch_pc = 8'h70; launch_mask = 4'h3;
    @(negedge clk);
    launch_vld = 1'b0;
    chk_top("R2 abort", 8'h70, 4'h3, 8'hFF, 2'd0, 1'b0);
    chk("R2 abort busy", {31'b0, busy}, 32'd0);
    chk("R2 abort done", {31'b0, done}, 32'd0);
    @(negedge clk);
    chk("R2 abort done later", {31'b0, done}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule